// File: doc/BRIEF.md
# Byte-Port Packet Mailbox

This block passes whole frames between a host processor and a simple packet engine through a small register file on a 32-bit bus. On the device side, frames arrive as a byte stream with start and end markers and are held in a single on-chip receive buffer. The host learns the frame length from a counter. It then pulls the bytes out through a byte-wide data register, and the counter falls by one with each pull. For transmit, the host programs a byte count and then writes that many bytes to a transmit data register. Each accepted byte leaves on the outgoing byte stream one cycle later, with start and end markers attached.

One level interrupt line covers three pending conditions: transmit finished, receive frame available, and a software self-test interrupt. While the receive condition is pending, the receiver ignores new frames, so the buffered frame cannot be overwritten before the host has released it. An identification register lets software probe for the block.

The bus uses byte addresses with 32-bit words. Reads are registered: `rdata_o` holds the addressed value from the cycle after `rd_en_i`. Register offsets: 0x00 and 0x04 identification, 0x08 busy, 0x0C receive count, 0x10 transmit count, 0x14 interrupt control, 0x18 interrupt info, 0x1C receive data, 0x20 transmit data.

Top module: `pkt_mailbox`

## Requirements
- R1: After reset, `irq_o` is low, `rdata_o` is zero, and the busy, receive count, transmit count and interrupt control registers all read zero.
- R2: Offset 0x00 reads 0x4D544B50 and offset 0x04 reads {8'h30+VERSION, 8'h58, 8'h4F, 8'h42}. These are the bytes "PKTMBOX" followed by the version digit, lowest byte first. Offset 0x18 reads the parameter IRQ_INFO.
- R3: A frame that ends (its `rx_eof_i` byte arrives) while interrupt control bit 1 is clear loads the receive count with the frame length, saturated at RX_DEPTH, and sets bit 1 one cycle later. Bytes beyond RX_DEPTH are dropped.
- R4: Each read of 0x1C returns the next buffered byte in arrival order in bits 7:0, with bits 31:8 zero, and lowers the receive count by one. A read of 0x1C while the count is zero returns zero and leaves the count at zero.
- R5: While interrupt control bit 1 is set, incoming frames are discarded. The receive count and the buffered bytes do not change.
- R6: The busy register (bit 0 at 0x08) reads 1 while a receive frame has started but not ended, or while programmed transmit bytes remain. Otherwise it reads 0.
- R7: A write to 0x10 sets the transmit count to the written value, clamped to MAX_LEN. Reading 0x10 returns that count until the frame is taken.
- R8: While transmit bytes remain, each write to 0x20 sends bits 7:0 on `tx_data_o` with a one-cycle `tx_valid_o` pulse in the next cycle. `tx_sof_o` marks the first byte and `tx_eof_o` marks the last. After the last byte, the transmit count reads zero and interrupt control bit 0 is set.
- R9: Writes to 0x20 when no transmit bytes remain produce no output pulse.
- R10: Writing 1 to interrupt control bit 0 or bit 1 clears that bit. Writing 0 to those bits leaves them unchanged.
- R11: Writing a word with bit 31 set to 0x14 raises a test interrupt. The first following read of 0x14 shows bit 31 set, and later reads show it clear. The test interrupt stays pending until the value 0 is written to 0x14.
- R12: `irq_o` is high exactly when transmit-done, receive-available or the test interrupt is pending. A read alone never lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_data_i | input | 8 | Incoming byte |
| rx_sof_i | input | 1 | Incoming byte is the first of a frame |
| rx_eof_i | input | 1 | Incoming byte is the last of a frame |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_data_o | output | 8 | Outgoing byte |
| tx_sof_o | output | 1 | Outgoing byte is the first of a frame |
| tx_eof_o | output | 1 | Outgoing byte is the last of a frame |
| irq_o | output | 1 | Level interrupt |

## Verification
The receive path is tested with every frame length from one byte up to four bytes past the buffer depth. The exact-fit and overflow lengths show whether the saturation point is off by one, and the single-byte frame exercises the case where the start and end markers arrive on the same byte. Each byte is checked against a seed-dependent pattern. The count is read after every pull, so a mis-ordered buffer or a missed decrement shows up at the exact byte where it happens. Transmit is tested with lengths one to eight and with a clamped over-limit count. The data words carry junk in their upper bits, which shows whether the first/last markers or the byte lane are wrong. A second frame offered while the first is unreleased, and a write of 0 to the control bits, check the hold-off behaviour and the set-on-1 clearing rule.

// File: rtl/pkt_mailbox_pkg.sv
package pkt_mailbox_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_ID_LO = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_ID_HI = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_BUSY  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_RXCNT = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_TXCNT = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_INFO  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_RXD   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_TXD   = 6'h20;

  // "PKTM" lowest byte first; high word is "BOX" plus version digit
  localparam logic [31:0] ID_LO_WORD = 32'h4D54_4B50;
  localparam logic [23:0] ID_HI_TAIL = 24'h58_4F42;

  localparam int BIT_TXDONE = 0;
  localparam int BIT_RXAVL  = 1;
  localparam int BIT_TEST   = 31;
endpackage

// File: rtl/mbox_rx.sv
module mbox_rx #(
  parameter int RX_DEPTH = 64,
  parameter int CNT_W    = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_sof_i,
  input  logic             rx_eof_i,
  input  logic             pend_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       byte_o,
  output logic             load_o,
  output logic             busy_o
);
  localparam int PTR_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(RX_DEPTH);

  logic [7:0]       mem_q [RX_DEPTH];
  logic             in_frame_q;
  logic [CNT_W-1:0] len_q, cnt_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic             start, take, room;
  logic [CNT_W-1:0] base, len_nxt;

  assign start   = rx_valid_i && rx_sof_i && !pend_i;
  assign take    = start || (rx_valid_i && in_frame_q);
  assign base    = start ? '0 : len_q;
  assign room    = base < DEPTH_C;
  assign len_nxt = room ? base + 1'b1 : base;
  assign load_o  = take && rx_eof_i;
  assign busy_o  = in_frame_q;
  assign cnt_o   = cnt_q;
  assign byte_o  = (cnt_q != '0) ? mem_q[rd_ptr_q] : 8'h00;

  always_ff @(posedge clk_i) begin
    if (take && room) mem_q[base[PTR_W-1:0]] <= rx_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      len_q      <= '0;
    end else if (take) begin
      in_frame_q <= !rx_eof_i;
      len_q      <= len_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
    end else if (load_o) begin
      cnt_q    <= len_nxt;
      rd_ptr_q <= '0;
    end else if (rd_i && cnt_q != '0) begin
      cnt_q    <= cnt_q - 1'b1;
      rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  AST_RX_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && cnt_q != '0 && !load_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_RX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !rd_i) |=> $stable(cnt_q)); // R5
  AST_RX_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C); // R3
endmodule

// File: rtl/mbox_tx.sv
module mbox_tx #(
  parameter int MAX_LEN = 65536,
  parameter int CNT_W   = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cnt_i,
  input  logic             wr_data_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_sof_o,
  output logic             tx_eof_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);

  logic [CNT_W-1:0] cnt_q, left_q, clamp;
  logic             send;

  assign clamp  = (wdata_i > 32'(MAX_LEN)) ? MAX_C : wdata_i[CNT_W-1:0];
  assign send   = wr_data_i && left_q != '0;
  assign done_o = send && left_q == CNT_W'(1);
  assign busy_o = left_q != '0;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      left_q <= '0;
    end else if (wr_cnt_i) begin
      cnt_q  <= clamp;
      left_q <= clamp;
    end else if (send) begin
      left_q <= left_q - 1'b1;
      if (done_o) cnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      tx_sof_o   <= 1'b0;
      tx_eof_o   <= 1'b0;
    end else begin
      tx_valid_o <= send;
      tx_sof_o   <= send && left_q == cnt_q;
      tx_eof_o   <= done_o;
      if (send) tx_data_o <= wdata_i[7:0];
    end
  end

  AST_TX_LEFT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q <= cnt_q) && (cnt_q <= MAX_C)); // R7
  AST_TX_LAST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_eof_o) |-> (cnt_q == '0 || $past(wr_cnt_i))); // R8
  AST_TX_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == '0) |=> !tx_valid_o); // R9
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import pkt_mailbox_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_ctrl_i,
  input  logic        rd_ctrl_i,
  input  logic [31:0] wdata_i,
  input  logic        tx_done_i,
  input  logic        rx_load_i,
  output logic [31:0] ctrl_o,
  output logic        rx_pend_o,
  output logic        irq_o
);
  logic tx_done_q, rx_avl_q, test_bit_q, test_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_done_q   <= 1'b0;
      rx_avl_q    <= 1'b0;
      test_bit_q  <= 1'b0;
      test_pend_q <= 1'b0;
    end else begin
      if (tx_done_i)                           tx_done_q <= 1'b1;
      else if (we_ctrl_i && wdata_i[BIT_TXDONE]) tx_done_q <= 1'b0;
      if (rx_load_i)                           rx_avl_q <= 1'b1;
      else if (we_ctrl_i && wdata_i[BIT_RXAVL])  rx_avl_q <= 1'b0;
      if (we_ctrl_i && wdata_i[BIT_TEST])      test_bit_q <= 1'b1;
      else if (rd_ctrl_i)                      test_bit_q <= 1'b0;
      if (we_ctrl_i && wdata_i[BIT_TEST])      test_pend_q <= 1'b1;
      else if (we_ctrl_i && wdata_i == '0)     test_pend_q <= 1'b0;
    end
  end

  assign ctrl_o    = {test_bit_q, 29'b0, rx_avl_q, tx_done_q};
  assign rx_pend_o = rx_avl_q;
  assign irq_o     = tx_done_q | rx_avl_q | test_pend_q;

  AST_TEST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl_i && !we_ctrl_i) |=> !test_bit_q); // R11
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_ctrl_i) |=> irq_o); // R12
  AST_TEST_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_ctrl_i && wdata_i[BIT_TEST]) |=> (irq_o && test_bit_q)); // R11
endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
  import pkt_mailbox_pkg::*;
#(
  parameter int          MAX_LEN  = 65536,
  parameter int          RX_DEPTH = 64,
  parameter int          VERSION  = 1,
  parameter logic [31:0] IRQ_INFO = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [31:0] ID_HI_WORD = {8'(8'h30 + VERSION), ID_HI_TAIL};

  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [7:0]       rx_byte;
  logic             rx_load, rx_busy, rx_pend, tx_busy, tx_done;
  logic [31:0]      ctrl, rd_mux;
  logic             rd_rxd, rd_ctrl, wr_ctrl, wr_txc, wr_txd;

  assign rd_rxd  = rd_en_i && addr_i == OFF_RXD;
  assign rd_ctrl = rd_en_i && addr_i == OFF_CTRL;
  assign wr_ctrl = we_i && addr_i == OFF_CTRL;
  assign wr_txc  = we_i && addr_i == OFF_TXCNT;
  assign wr_txd  = we_i && addr_i == OFF_TXD;

  mbox_rx #(.RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .rx_sof_i, .rx_eof_i,
    .pend_i(rx_pend), .rd_i(rd_rxd), .cnt_o(rx_cnt), .byte_o(rx_byte),
    .load_o(rx_load), .busy_o(rx_busy)
  );

  mbox_tx #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni, .wr_cnt_i(wr_txc), .wr_data_i(wr_txd), .wdata_i,
    .cnt_o(tx_cnt), .busy_o(tx_busy), .done_o(tx_done),
    .tx_valid_o, .tx_data_o, .tx_sof_o, .tx_eof_o
  );

  mbox_irq u_irq (
    .clk_i, .rst_ni, .we_ctrl_i(wr_ctrl), .rd_ctrl_i(rd_ctrl), .wdata_i,
    .tx_done_i(tx_done), .rx_load_i(rx_load), .ctrl_o(ctrl),
    .rx_pend_o(rx_pend), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      OFF_ID_LO: rd_mux = ID_LO_WORD;
      OFF_ID_HI: rd_mux = ID_HI_WORD;
      OFF_BUSY:  rd_mux = {31'b0, rx_busy | tx_busy};
      OFF_RXCNT: rd_mux = {{(32-CNT_W){1'b0}}, rx_cnt};
      OFF_TXCNT: rd_mux = {{(32-CNT_W){1'b0}}, tx_cnt};
      OFF_CTRL:  rd_mux = ctrl;
      OFF_INFO:  rd_mux = IRQ_INFO;
      OFF_RXD:   rd_mux = {24'b0, rx_byte};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  AST_RXD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i == OFF_RXD) |-> (rdata_o[31:8] == '0)); // R4
  AST_BUSY_ON_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txc && wdata_i != '0) |=> (tx_busy | rx_busy)); // R6
endmodule

// File: tb/tb_pkt_mailbox.sv
module tb_pkt_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL  = 40;
  localparam int DEPTH = 16;
  localparam int VER   = 3;
  localparam logic [31:0] INFO = 32'h5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        rxv = 1'b0, rxs = 1'b0, rxe = 1'b0;
  logic [7:0]  rxd = '0;
  logic        txv, txs, txe, irq;
  logic [7:0]  txd;

  int checks = 0, errors = 0;
  logic [7:0] cap_d [256];
  logic       cap_s [256];
  logic       cap_e [256];
  int         cap_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_mailbox #(.MAX_LEN(MAXL), .RX_DEPTH(DEPTH), .VERSION(VER), .IRQ_INFO(INFO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rxv), .rx_data_i(rxd),
    .rx_sof_i(rxs), .rx_eof_i(rxe), .tx_valid_o(txv), .tx_data_o(txd),
    .tx_sof_o(txs), .tx_eof_o(txe), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (txv && cap_n < 256) begin
      cap_d[cap_n] = txd;
      cap_s[cap_n] = txs;
      cap_e[cap_n] = txe;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdr(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic send(int len, int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rxv = 1'b1; rxd = pat(seed, k); rxs = (k == 0); rxe = (k == len - 1);
    end
    @(negedge clk);
    rxv = 1'b0; rxs = 1'b0; rxe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    rdr(6'h08, v); chk("R1 busy", v, 0);
    rdr(6'h0C, v); chk("R1 rxcnt", v, 0);
    rdr(6'h10, v); chk("R1 txcnt", v, 0);
    rdr(6'h14, v); chk("R1 ctrl", v, 0);
    // R2 identification
    rdr(6'h00, v); chk("R2 id_lo", v, 32'h4D544B50);
    rdr(6'h04, v); chk("R2 id_hi", v, {8'(8'h30 + VER), 24'h584F42});
    rdr(6'h18, v); chk("R2 info", v, INFO);

    // R3 R4 receive sweep over lengths 1..DEPTH+4
    for (int len = 1; len <= DEPTH + 4; len++) begin
      int exp_n;
      exp_n = (len < DEPTH) ? len : DEPTH;
      send(len, len);
      rdr(6'h14, v); chk("R3 rx avail bit", v, 32'h2);
      chk("R12 irq on rx", {31'b0, irq}, 1);
      rdr(6'h0C, v); chk("R3 rx length", v, exp_n);
      for (int k = 0; k < exp_n; k++) begin
        rdr(6'h1C, v); chk("R4 rx byte", v, {24'b0, pat(len, k)});
        rdr(6'h0C, v); chk("R4 rx count step", v, exp_n - k - 1);
      end
      rdr(6'h1C, v); chk("R4 empty read", v, 0);
      rdr(6'h0C, v); chk("R4 count stays zero", v, 0);
      wr(6'h14, 32'h2);
      rdr(6'h14, v); chk("R10 rx bit cleared", v, 0);
      chk("R12 irq low", {31'b0, irq}, 0);
    end

    // R5 hold-off and R10 write-0 ignored
    send(3, 91);
    send(5, 92);
    rdr(6'h0C, v); chk("R5 count held", v, 3);
    wr(6'h14, 32'h0);
    rdr(6'h14, v); chk("R10 write 0 keeps bit1", v, 32'h2);
    for (int k = 0; k < 3; k++) begin
      rdr(6'h1C, v); chk("R5 first frame kept", v, {24'b0, pat(91, k)});
    end
    wr(6'h14, 32'h2);

    // R6 busy during receive
    @(negedge clk); rxv = 1'b1; rxd = 8'hA5; rxs = 1'b1; rxe = 1'b0;
    @(negedge clk); rxv = 1'b0; rxs = 1'b0;
    rdr(6'h08, v); chk("R6 busy mid rx", v, 1);
    @(negedge clk); rxv = 1'b1; rxd = 8'h5A; rxe = 1'b1;
    @(negedge clk); rxv = 1'b0; rxe = 1'b0;
    rdr(6'h08, v); chk("R6 busy after rx", v, 0);
    rdr(6'h0C, v); chk("R3 two-byte frame", v, 2);
    wr(6'h14, 32'h2);

    // R7 R8 R9 transmit sweep
    for (int len = 1; len <= 8; len++) begin
      base = cap_n;
      wr(6'h10, len);
      rdr(6'h10, v); chk("R7 tx count", v, len);
      rdr(6'h08, v); chk("R6 busy tx", v, 1);
      for (int k = 0; k < len; k++) wr(6'h20, {24'hABCD00, pat(len + 50, k)});
      @(negedge clk);
      chk("R8 tx byte total", cap_n - base, len);
      for (int k = 0; k < len; k++) begin
        chk("R8 tx data", {24'b0, cap_d[base + k]}, {24'b0, pat(len + 50, k)});
        chk("R8 tx sof", {31'b0, cap_s[base + k]}, (k == 0) ? 1 : 0);
        chk("R8 tx eof", {31'b0, cap_e[base + k]}, (k == len - 1) ? 1 : 0);
      end
      rdr(6'h10, v); chk("R8 tx count cleared", v, 0);
      rdr(6'h14, v); chk("R8 tx done bit", v, 32'h1);
      rdr(6'h08, v); chk("R6 busy idle", v, 0);
      chk("R12 irq on tx", {31'b0, irq}, 1);
      base = cap_n;
      wr(6'h20, 32'h77); wr(6'h20, 32'h78);
      @(negedge clk);
      chk("R9 extra writes dropped", cap_n - base, 0);
      wr(6'h14, 32'h1);
      rdr(6'h14, v); chk("R10 tx bit cleared", v, 0);
    end

    // R7 clamp
    wr(6'h10, 32'd100);
    rdr(6'h10, v); chk("R7 clamp", v, MAXL);
    base = cap_n;
    for (int k = 0; k < MAXL; k++) wr(6'h20, k);
    @(negedge clk);
    chk("R8 clamped frame size", cap_n - base, MAXL);
    chk("R8 clamped eof", {31'b0, cap_e[base + MAXL - 1]}, 1);
    wr(6'h14, 32'h1);

    // R11 test interrupt
    wr(6'h14, 32'h8000_0000);
    chk("R11 irq raised", {31'b0, irq}, 1);
    rdr(6'h14, v); chk("R11 first read", v, 32'h8000_0000);
    rdr(6'h14, v); chk("R11 second read", v, 0);
    chk("R12 irq held after read", {31'b0, irq}, 1);
    wr(6'h14, 32'h0);
    chk("R11 irq cleared", {31'b0, irq}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule